// File: doc/BRIEF.md
# Per-Circuit Powering Interlock Controller

This block decides, cycle by cycle, whether one superconducting magnet circuit may carry current. It watches three status lines from the circuit: the quench-protection loop, the converter health summary and the coolant condition. It also watches a global interlock qualifier and a start-up qualifier. From these it drives active-high "loop closed" lines to the power converter: a main permit, a second permit, a fast-abort loop and a discharge-request loop. A high level on any of these lines means the loop is intact and nothing is requested. A low level means the loop is open, which is the safe state.

A static class input selects which of these lines the circuit uses, from four interlock classes. Every loss of a powering condition is latched. The circuit is re-armed only by a fixed operator sequence:

1. An unlatch command, which is refused while any global interlock is pending or a fault is still present.
2. A converter-clear command, after which the circuit reports ready.
3. A permit request, which is granted only while the start-up qualifier is good.

The three circuit status lines pass through a two-flop synchroniser and a deglitch filter of `FILT_LEN` cycles.

Top module: `pwr_ilk_ctrl`

## Requirements
- R1: While reset is asserted and right after its release, every output is low: permits off, abort loop open, discharge loop open, ready low.
- R2: The class code `cls_i` is 0 for the full class, 1 for single-permit quench class, 2 for dual-permit quench class and 3 for the permit-only class. `permit2_o` is used only in class 2, `abort_ok_o` only in classes 0 to 2, and `dischg_ok_o` only in class 0. A line that the class does not use is held low.
- R3: An unlatch command given while `glob_ok_i` is low is refused, so a following converter-clear does not raise `ready_o` and the abort loop stays open.
- R4: A converter-clear command is accepted only after an accepted unlatch, and it raises `ready_o`. A clear given while still latched has no effect, and `ready_o` never coincides with a granted permit.
- R5: A permit request raises the permits only when `ready_o` is high and `startup_ok_i` is high. A request made while `startup_ok_i` is low is ignored.
- R6: In classes 0 to 2, an open quench loop (`circuit_ok_i` low for at least `FILT_LEN` cycles) removes the permits and opens the abort loop. Both stay that way after the loop closes again, until the next re-arm sequence.
- R7: In every class, a converter failure (`conv_ok_i` low) removes the permits. They stay removed after the line recovers, until the next re-arm sequence.
- R8: In class 0, coolant loss (`coolant_ok_i` low) opens the discharge loop and removes the permits, both latched. In other classes the coolant line is ignored.
- R9: When `glob_ok_i` goes low, the permits are removed at the next clock edge. In classes 0 to 2 the abort loop also opens at that edge.
- R10: Loss of `startup_ok_i` while the permit is granted does not remove the permit.
- R11: A low pulse on a filtered status line that is shorter than `FILT_LEN` cycles has no effect on the outputs.
- R12: In class 3 the quench line is ignored: a long low level on `circuit_ok_i` leaves a granted permit in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cls_i | input | 2 | Interlock class code, static outside reset |
| circuit_ok_i | input | 1 | Quench loop closed (high = no quench) |
| conv_ok_i | input | 1 | Converter healthy (low = powering failure) |
| coolant_ok_i | input | 1 | Coolant present (low = loss of coolant) |
| glob_ok_i | input | 1 | No global interlock pending |
| startup_ok_i | input | 1 | No start-up interlock pending |
| unlatch_i | input | 1 | Unlatch (init) command, one-cycle pulse |
| clear_i | input | 1 | Converter fault clear command, one-cycle pulse |
| permit_req_i | input | 1 | Permit request, one-cycle pulse |
| permit1_o | output | 1 | Main powering permit loop closed |
| permit2_o | output | 1 | Second powering permit loop closed |
| abort_ok_o | output | 1 | Fast-abort loop closed (high = no abort) |
| dischg_ok_o | output | 1 | Discharge loop closed (high = no discharge request) |
| ready_o | output | 1 | Circuit ready to accept a permit |

## Verification
The assertions assume the following about the inputs:
- `cls_i` changes only while reset is asserted.
- The three commands arrive as single-cycle pulses.
- All inputs change synchronously to the clock.

The bench changes class only inside a reset sequence. It drives every input on the falling edge and pulses each command for exactly one cycle. Fault levels are held for more cycles than the synchroniser and filter latency before any output is sampled.

// File: rtl/pwr_ilk_pkg.sv
`timescale 1ns/1ps
package pwr_ilk_pkg;

  typedef enum logic [1:0] {
    CLS_FULL = 2'd0,
    CLS_QSGL = 2'd1,
    CLS_QDUAL = 2'd2,
    CLS_PONLY = 2'd3
  } ilk_cls_e;

  typedef enum logic [1:0] {
    ST_LOCK = 2'd0,
    ST_UNL  = 2'd1,
    ST_RDY  = 2'd2,
    ST_ON   = 2'd3
  } ilk_st_e;

  localparam int NUM_STAT = 3;
  localparam int IDX_CIRC = 0;
  localparam int IDX_CONV = 1;
  localparam int IDX_COOL = 2;

endpackage

// File: rtl/pwr_ilk_filt.sv
`timescale 1ns/1ps
module pwr_ilk_filt #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(FILT_LEN - 1);

  logic [1:0]    sync_q;
  logic          filt_q, filt_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    filt_d = filt_q;
    cnt_d  = cnt_q;
    if (sync_q[1] == filt_q) begin
      cnt_d = '0;
    end else if (cnt_q == CNT_LAST) begin
      filt_d = sync_q[1];
      cnt_d  = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      filt_q <= filt_d;
      cnt_q  <= cnt_d;
    end
  end

  assign filt_o = filt_q;
endmodule

// File: rtl/pwr_ilk_seq.sv
`timescale 1ns/1ps
module pwr_ilk_seq
  import pwr_ilk_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          cls_i,
  input  logic [NUM_STAT-1:0] stat_ok_i,
  input  logic                glob_ok_i,
  input  logic                startup_ok_i,
  input  logic                unlatch_i,
  input  logic                clear_i,
  input  logic                permit_req_i,
  output logic                permit1_o,
  output logic                permit2_o,
  output logic                abort_ok_o,
  output logic                dischg_ok_o,
  output logic                ready_o
);
  ilk_st_e st_q, st_d;
  logic    abt_lat_q, abt_lat_d;
  logic    dis_lat_q, dis_lat_d;
  logic    uses_quench, uses_cool, dual_perm;
  logic    trip, unl_ok;

  assign uses_quench = (cls_i != CLS_PONLY);
  assign uses_cool   = (cls_i == CLS_FULL);
  assign dual_perm   = (cls_i == CLS_QDUAL);

  assign trip = !glob_ok_i
              | !stat_ok_i[IDX_CONV]
              | (uses_quench & !stat_ok_i[IDX_CIRC])
              | (uses_cool & !stat_ok_i[IDX_COOL]);

  assign unl_ok = (st_q == ST_LOCK) && unlatch_i && !trip;

  always_comb begin
    st_d = st_q;
    if (trip) begin
      st_d = ST_LOCK;
    end else begin
      unique case (st_q)
        ST_LOCK: if (unlatch_i) st_d = ST_UNL;
        ST_UNL:  if (clear_i)   st_d = ST_RDY;
        ST_RDY:  if (permit_req_i && startup_ok_i) st_d = ST_ON;
        ST_ON:   st_d = ST_ON;
        default: st_d = ST_LOCK;
      endcase
    end
  end

  always_comb begin
    abt_lat_d = abt_lat_q;
    if (unl_ok) abt_lat_d = 1'b0;
    if (uses_quench && (!stat_ok_i[IDX_CIRC] || !glob_ok_i)) abt_lat_d = 1'b1;
  end

  always_comb begin
    dis_lat_d = dis_lat_q;
    if (unl_ok) dis_lat_d = 1'b0;
    if (uses_cool && !stat_ok_i[IDX_COOL]) dis_lat_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_LOCK;
      abt_lat_q <= 1'b1;
      dis_lat_q <= 1'b1;
    end else begin
      st_q      <= st_d;
      abt_lat_q <= abt_lat_d;
      dis_lat_q <= dis_lat_d;
    end
  end

  assign permit1_o   = (st_q == ST_ON);
  assign permit2_o   = (st_q == ST_ON) && dual_perm;
  assign abort_ok_o  = uses_quench && !abt_lat_q;
  assign dischg_ok_o = uses_cool && !dis_lat_q;
  assign ready_o     = (st_q == ST_RDY);
endmodule

// File: rtl/pwr_ilk_ctrl.sv
`timescale 1ns/1ps
module pwr_ilk_ctrl
  import pwr_ilk_pkg::*;
#(
  parameter int FILT_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cls_i,
  input  logic       circuit_ok_i,
  input  logic       conv_ok_i,
  input  logic       coolant_ok_i,
  input  logic       glob_ok_i,
  input  logic       startup_ok_i,
  input  logic       unlatch_i,
  input  logic       clear_i,
  input  logic       permit_req_i,
  output logic       permit1_o,
  output logic       permit2_o,
  output logic       abort_ok_o,
  output logic       dischg_ok_o,
  output logic       ready_o
);
  logic [1:0]          rst_sync_q;
  logic                rst_int_n;
  logic [NUM_STAT-1:0] stat_raw;
  logic [NUM_STAT-1:0] stat_flt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign stat_raw[IDX_CIRC] = circuit_ok_i;
  assign stat_raw[IDX_CONV] = conv_ok_i;
  assign stat_raw[IDX_COOL] = coolant_ok_i;

  for (genvar g = 0; g < NUM_STAT; g++) begin : g_filt
    pwr_ilk_filt #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .raw_i  (stat_raw[g]),
      .filt_o (stat_flt[g])
    );
  end

  pwr_ilk_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .cls_i        (cls_i),
    .stat_ok_i    (stat_flt),
    .glob_ok_i    (glob_ok_i),
    .startup_ok_i (startup_ok_i),
    .unlatch_i    (unlatch_i),
    .clear_i      (clear_i),
    .permit_req_i (permit_req_i),
    .permit1_o    (permit1_o),
    .permit2_o    (permit2_o),
    .abort_ok_o   (abort_ok_o),
    .dischg_ok_o  (dischg_ok_o),
    .ready_o      (ready_o)
  );
endmodule

// File: rtl/pwr_ilk_chk.sv
`timescale 1ns/1ps
module pwr_ilk_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cls_i,
  input logic       glob_ok_i,
  input logic       startup_ok_i,
  input logic       unlatch_i,
  input logic       permit1_o,
  input logic       permit2_o,
  input logic       abort_ok_o,
  input logic       dischg_ok_o,
  input logic       ready_o
);
  AST_PERMIT_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(permit1_o) |-> $past(ready_o)); // R5
  AST_PERMIT_NEEDS_STARTUP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(permit1_o) |-> $past(startup_ok_i)); // R5
  AST_GLOBAL_DROPS_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_ok_i |=> !permit1_o); // R9
  AST_GLOBAL_BLOCKS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_ok_i |=> !ready_o); // R3
  AST_PERMIT2_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    permit2_o |-> (cls_i == 2'd2)); // R2
  AST_DISCHG_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    dischg_ok_o |-> (cls_i == 2'd0)); // R2
  AST_ABORT_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ok_o |-> (cls_i != 2'd3)); // R2
  AST_READY_PERMIT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready_o && permit1_o)); // R4
  AST_ABORT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (!abort_ok_o && !unlatch_i) |=> !abort_ok_o); // R6
endmodule

bind pwr_ilk_ctrl pwr_ilk_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cls_i        (cls_i),
  .glob_ok_i    (glob_ok_i),
  .startup_ok_i (startup_ok_i),
  .unlatch_i    (unlatch_i),
  .permit1_o    (permit1_o),
  .permit2_o    (permit2_o),
  .abort_ok_o   (abort_ok_o),
  .dischg_ok_o  (dischg_ok_o),
  .ready_o      (ready_o)
);

// File: tb/pwr_ilk_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_ilk_ctrl_tb;
  localparam int FL = 3;
  localparam int SETTLE = FL + 5;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] cls;
  logic circ_ok, conv_ok, cool_ok, glob_ok, su_ok, unl, clr, req;
  logic p1, p2, abt, dis, rdy;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwr_ilk_ctrl #(.FILT_LEN(FL)) u_dut (
    .clk(clk), .rst_n(rst_n), .cls_i(cls),
    .circuit_ok_i(circ_ok), .conv_ok_i(conv_ok), .coolant_ok_i(cool_ok),
    .glob_ok_i(glob_ok), .startup_ok_i(su_ok),
    .unlatch_i(unl), .clear_i(clr), .permit_req_i(req),
    .permit1_o(p1), .permit2_o(p2), .abort_ok_o(abt),
    .dischg_ok_o(dis), .ready_o(rdy)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s class=%0d act=%0b exp=%0b", tag, cls, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_unl(); unl = 1'b1; wait_n(1); unl = 1'b0; endtask
  task automatic pulse_clr(); clr = 1'b1; wait_n(1); clr = 1'b0; endtask
  task automatic pulse_req(); req = 1'b1; wait_n(1); req = 1'b0; endtask

  task automatic full_arm();
    wait_n(SETTLE);
    pulse_unl();
    pulse_clr();
    pulse_req();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cls = 2'd0;
    circ_ok = 1; conv_ok = 1; cool_ok = 1; glob_ok = 1; su_ok = 1;
    unl = 0; clr = 0; req = 0;
    for (int c = 0; c < 4; c++) begin
      wait_n(1);
      rst_n = 1'b0; cls = 2'(c);
      circ_ok = 1; conv_ok = 1; cool_ok = 1; glob_ok = 1; su_ok = 1;
      wait_n(3);
      chk("R1 permit1 in reset", p1, 1'b0);
      chk("R1 abort in reset", abt, 1'b0);
      rst_n = 1'b1;
      wait_n(1);
      chk("R1 permit1", p1, 1'b0);
      chk("R1 permit2", p2, 1'b0);
      chk("R1 abort", abt, 1'b0);
      chk("R1 dischg", dis, 1'b0);
      chk("R1 ready", rdy, 1'b0);
      wait_n(SETTLE);
      // R4: clear while latched
      pulse_clr();
      chk("R4 clear before unlatch", rdy, 1'b0);
      // R3: unlatch refused under global interlock
      glob_ok = 0; pulse_unl(); glob_ok = 1;
      wait_n(1); pulse_clr();
      chk("R3 ready after refused unlatch", rdy, 1'b0);
      chk("R3 abort after refused unlatch", abt, 1'b0);
      // arm sequence
      pulse_unl();
      chk("R2 abort line per class", abt, c != 3);
      chk("R2 dischg line per class", dis, c == 0);
      pulse_clr();
      chk("R4 ready after clear", rdy, 1'b1);
      su_ok = 0; pulse_req();
      chk("R5 request with startup pending", p1, 1'b0);
      chk("R5 still ready", rdy, 1'b1);
      su_ok = 1; pulse_req();
      chk("R5 permit1 granted", p1, 1'b1);
      chk("R2 permit2 per class", p2, c == 2);
      chk("R4 ready drops with permit", rdy, 1'b0);
      // R10
      su_ok = 0; wait_n(6);
      chk("R10 startup loss while on", p1, 1'b1);
      su_ok = 1;
      // R11: short glitches on each line
      circ_ok = 0; wait_n(FL - 1); circ_ok = 1; wait_n(SETTLE);
      chk("R11 quench glitch permit", p1, 1'b1);
      chk("R11 quench glitch abort", abt, c != 3);
      conv_ok = 0; wait_n(FL - 1); conv_ok = 1; wait_n(SETTLE);
      chk("R11 converter glitch permit", p1, 1'b1);
      // R6 / R12: real quench
      circ_ok = 0; wait_n(SETTLE);
      if (c != 3) begin
        chk("R6 quench drops permit", p1, 1'b0);
        chk("R6 quench opens abort", abt, 1'b0);
      end else begin
        chk("R12 quench ignored", p1, 1'b1);
      end
      circ_ok = 1; wait_n(SETTLE);
      if (c != 3) begin
        chk("R6 permit stays latched", p1, 1'b0);
        chk("R6 abort stays latched", abt, 1'b0);
        full_arm();
        chk("R6 re-armed", p1, 1'b1);
      end
      // R8: coolant
      cool_ok = 0; wait_n(SETTLE);
      if (c == 0) begin
        chk("R8 coolant loss permit", p1, 1'b0);
        chk("R8 coolant loss dischg", dis, 1'b0);
      end else begin
        chk("R8 coolant ignored", p1, 1'b1);
      end
      cool_ok = 1; wait_n(SETTLE);
      if (c == 0) begin
        chk("R8 dischg stays latched", dis, 1'b0);
        full_arm();
        chk("R8 dischg restored", dis, 1'b1);
      end
      // R7: converter failure
      conv_ok = 0; wait_n(SETTLE);
      chk("R7 failure drops permit1", p1, 1'b0);
      chk("R7 failure drops permit2", p2, 1'b0);
      conv_ok = 1; wait_n(SETTLE);
      chk("R7 permit stays latched", p1, 1'b0);
      full_arm();
      chk("R7 re-armed", p1, 1'b1);
      // R9: global interlock
      glob_ok = 0; wait_n(1);
      chk("R9 global drops permit", p1, 1'b0);
      chk("R9 global abort", abt, 1'b0);
      glob_ok = 1;
      full_arm();
      chk("R9 re-armed permit", p1, 1'b1);
      chk("R9 re-armed abort", abt, c != 3);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule